// File: doc/BRIEF.md
# Receive Special Character Matcher

This block sits between a UART receiver's deserializer and its receive FIFO. Every character the receiver delivers is forwarded to the FIFO write port one clock later. Bits above the programmed word length are forced to zero. The FIFO still receives a character that matches the special character.

While detection is enabled, the block also compares each received character with a programmed special character. The comparison covers only as many low-order bits as the current word length selects. A match sets a sticky detect flag, which host logic clears with an explicit clear pulse, for example on a status read.

A framing-error marker travels alongside each character. It does not affect the comparison.

Top module: `rx_spchar_match`

## Requirements
- R1: Every cycle with `rx_valid_i` high produces `fifo_wr_o` high on the following cycle. A cycle with `rx_valid_i` low produces `fifo_wr_o` low on the following cycle. This holds whether or not the character matches.
- R2: `wlen_i` selects the character width: 00 is 5 bits, 01 is 6, 10 is 7 and 11 is 8. On each FIFO write, `fifo_data_o` holds the received character with every bit at or above that width forced to zero.
- R3: The comparison uses only bit positions below the selected width. Bit 0 of `spchar_i` is compared with bit 0 of the received character. Differences in higher bits of either value have no effect on the result.
- R4: A received character that matches while `det_en_i` is high sets `det_flag_o`. The flag is visible in the same cycle as the corresponding `fifo_wr_o`.
- R5: While `det_en_i` is low, a matching character never sets `det_flag_o`.
- R6: `det_flag_o` stays high until `flag_clr_i` is pulsed. After a clear with no new match in that cycle, the flag reads low on the next cycle.
- R7: When a qualifying match and `flag_clr_i` arrive in the same cycle, the flag ends up set.
- R8: A character received with `rx_ferr_i` high is still compared and written to the FIFO. The error marker appears on `fifo_ferr_o` together with that write.
- R9: While `rst_n` is low, `fifo_wr_o`, `fifo_data_o`, `fifo_ferr_o` and `det_flag_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Received-character strobe |
| rx_data_i | input | 8 | Received character, LSB in bit 0 |
| rx_ferr_i | input | 1 | Framing error for the character |
| wlen_i | input | 2 | Word-length code |
| det_en_i | input | 1 | Special-character detection enable |
| spchar_i | input | 8 | Programmed special character |
| flag_clr_i | input | 1 | Clear pulse for the detect flag |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | FIFO write data, upper bits masked |
| fifo_ferr_o | output | 1 | Framing error passed along with the write |
| det_flag_o | output | 1 | Sticky special-character detect flag |

## Verification
The bench builds the block with its default 8-bit character and 2-bit word-length code. This gives exactly four widths, from 5 to 8 bits, so every word-length code and every masked upper bit can be reached.

Random stimulus often programs the special character as the received character with random upper bits. This makes partial-width matches frequent, and it makes upper-bit-only differences frequent as well. Directed cases add:
- a bit-0 mismatch,
- a disabled match,
- a match carrying a framing error,
- a match arriving together with a clear.

// File: rtl/rxsc_pkg.sv
package rxsc_pkg;
  localparam int unsigned CHAR_W_DEF = 8;
  localparam int unsigned WLEN_W_DEF = 2;

  typedef enum logic [1:0] {
    WLEN_5 = 2'b00,
    WLEN_6 = 2'b01,
    WLEN_7 = 2'b10,
    WLEN_8 = 2'b11
  } wlen_code_e;
endpackage

// File: rtl/rxsc_wlen_mask.sv
module rxsc_wlen_mask #(
  parameter int unsigned CHAR_W = rxsc_pkg::CHAR_W_DEF,
  parameter int unsigned WLEN_W = rxsc_pkg::WLEN_W_DEF
) (
  input  logic [WLEN_W-1:0] wlen_i,
  output logic [CHAR_W-1:0] mask_o
);
  localparam int unsigned MIN_W = CHAR_W - (2 ** WLEN_W) + 1;
  localparam int unsigned CNT_W = $clog2(CHAR_W + 1);

  logic [CNT_W-1:0] nbits;

  always_comb begin
    nbits = CNT_W'(MIN_W) + CNT_W'(wlen_i);
  end

  for (genvar gi = 0; gi < CHAR_W; gi++) begin : g_bit
    assign mask_o[gi] = (CNT_W'(gi) < nbits);
  end
endmodule

// File: rtl/rxsc_compare.sv
module rxsc_compare #(
  parameter int unsigned CHAR_W = rxsc_pkg::CHAR_W_DEF
) (
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic [CHAR_W-1:0] spchar_i,
  input  logic [CHAR_W-1:0] mask_i,
  output logic [CHAR_W-1:0] data_masked_o,
  output logic              match_o
);
  always_comb begin
    data_masked_o = rx_data_i & mask_i;
    match_o       = ~|((rx_data_i ^ spchar_i) & mask_i);
  end
endmodule

// File: rtl/rxsc_flag.sv
module rxsc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q);
endmodule

// File: rtl/rx_spchar_match.sv
module rx_spchar_match #(
  parameter int unsigned CHAR_W = rxsc_pkg::CHAR_W_DEF,
  parameter int unsigned WLEN_W = rxsc_pkg::WLEN_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid_i,
  input  logic [CHAR_W-1:0] rx_data_i,
  input  logic              rx_ferr_i,
  input  logic [WLEN_W-1:0] wlen_i,
  input  logic              det_en_i,
  input  logic [CHAR_W-1:0] spchar_i,
  input  logic              flag_clr_i,
  output logic              fifo_wr_o,
  output logic [CHAR_W-1:0] fifo_data_o,
  output logic              fifo_ferr_o,
  output logic              det_flag_o
);
  logic [CHAR_W-1:0] mask;
  logic [CHAR_W-1:0] data_masked;
  logic              match;
  logic              det_set;

  logic              wr_q, wr_d;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              ferr_q, ferr_d;
  logic              cap_en;

  rxsc_wlen_mask #(.CHAR_W(CHAR_W), .WLEN_W(WLEN_W)) u_mask (
    .wlen_i (wlen_i),
    .mask_o (mask)
  );

  rxsc_compare #(.CHAR_W(CHAR_W)) u_cmp (
    .rx_data_i     (rx_data_i),
    .spchar_i      (spchar_i),
    .mask_i        (mask),
    .data_masked_o (data_masked),
    .match_o       (match)
  );

  assign det_set = rx_valid_i & det_en_i & match;

  rxsc_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (det_set),
    .clr_i  (flag_clr_i),
    .flag_o (det_flag_o)
  );

  // Next state of the FIFO write stage
  always_comb begin
    cap_en = rx_valid_i;
    wr_d   = rx_valid_i;
    data_d = data_q;
    ferr_d = ferr_q;
    if (cap_en) begin
      data_d = data_masked;
      ferr_d = rx_ferr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      data_q <= '0;
      ferr_q <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      data_q <= data_d;
      ferr_q <= ferr_d;
    end
  end

  assign fifo_wr_o   = wr_q;
  assign fifo_data_o = data_q;
  assign fifo_ferr_o = ferr_q;

  // R1
  wr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_i |=> fifo_wr_o);
  // R1
  wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_i |=> !fifo_wr_o);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_i |=> ((fifo_data_o & ~$past(mask)) == '0));
  // R5
  disabled_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_flag_o) |-> $past(det_en_i && rx_valid_i));
  // R8
  ferr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_i |=> (fifo_ferr_o == $past(rx_ferr_i)));
  // R9
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!fifo_wr_o && !det_flag_o && !fifo_ferr_o && fifo_data_o == '0));
endmodule

// File: tb/rx_spchar_match_bench.sv
module rx_spchar_match_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid_i;
  logic [7:0] rx_data_i;
  logic       rx_ferr_i;
  logic [1:0] wlen_i;
  logic       det_en_i;
  logic [7:0] spchar_i;
  logic       flag_clr_i;
  logic       fifo_wr_o;
  logic [7:0] fifo_data_o;
  logic       fifo_ferr_o;
  logic       det_flag_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  logic exp_flag;
  bit  done = 0;

  always #4 clk = ~clk;

  rx_spchar_match u_rx_spchar_match (
    .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .rx_ferr_i(rx_ferr_i), .wlen_i(wlen_i), .det_en_i(det_en_i),
    .spchar_i(spchar_i), .flag_clr_i(flag_clr_i), .fifo_wr_o(fifo_wr_o),
    .fifo_data_o(fifo_data_o), .fifo_ferr_o(fifo_ferr_o), .det_flag_o(det_flag_o)
  );

  function automatic logic [7:0] width_mask(input logic [1:0] wl);
    return 8'hFF >> (2'd3 - wl);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [7:0] d, input logic [1:0] wl,
                     input logic en, input logic [7:0] sc, input logic fe,
                     input logic clr);
    logic       m;
    logic       full_eq;
    string      ftag;
    logic [7:0] exp_data;
    @(negedge clk);
    rx_valid_i = v; rx_data_i = d; wlen_i = wl; det_en_i = en;
    spchar_i = sc; rx_ferr_i = fe; flag_clr_i = clr;
    m        = ((d & width_mask(wl)) == (sc & width_mask(wl)));
    full_eq  = (d == sc);
    exp_data = d & width_mask(wl);
    if (v && en && m && clr)  ftag = "R7";
    else if (v && m != full_eq) ftag = "R3";
    else if (v && en && m)    ftag = "R4";
    else if (v && !en && m)   ftag = "R5";
    else                      ftag = "R6";
    if (v && en && m) exp_flag = 1'b1;
    else if (clr)     exp_flag = 1'b0;
    @(posedge clk);
    #2;
    chk("R1", 32'(fifo_wr_o), 32'(v));
    if (v) begin
      chk("R2", 32'(fifo_data_o), 32'(exp_data));
      chk("R8", 32'(fifo_ferr_o), 32'(fe));
    end
    chk(ftag, 32'(det_flag_o), 32'(exp_flag));
  endtask

  initial begin
    rst_n = 1'b0; rx_valid_i = 0; rx_data_i = 0; rx_ferr_i = 0; wlen_i = 0;
    det_en_i = 0; spchar_i = 0; flag_clr_i = 0; exp_flag = 0;
    repeat (3) @(posedge clk);
    #2;
    // R9
    chk("R9", {fifo_wr_o, fifo_ferr_o, det_flag_o}, 0);
    chk("R9", 32'(fifo_data_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // directed corner cases
    cyc(1, 8'hE5, 2'b00, 1, 8'h05, 0, 0); // R3 upper bits ignored at 5 bits
    cyc(0, 8'h00, 2'b00, 1, 8'h05, 0, 1); // R6 clear
    cyc(1, 8'hE5, 2'b11, 1, 8'h05, 0, 0); // R3 full width mismatch
    cyc(1, 8'h04, 2'b00, 1, 8'h05, 0, 0); // R3 bit 0 alignment
    cyc(1, 8'h45, 2'b01, 0, 8'h05, 0, 0); // R5 disabled match
    cyc(1, 8'h25, 2'b10, 1, 8'hA5, 1, 0); // R8 framing error still matches
    cyc(0, 8'h00, 2'b10, 1, 8'hA5, 0, 0); // R6 flag holds
    cyc(0, 8'h00, 2'b10, 1, 8'hA5, 0, 1);
    cyc(1, 8'h3C, 2'b11, 1, 8'h3C, 0, 1); // R7 set beats clear
    cyc(0, 8'h00, 2'b11, 1, 8'h3C, 0, 0);
    // constrained random
    void'($urandom(32'd20240607));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d, sc;
      d  = 8'($urandom);
      sc = ($urandom % 2) ? (d ^ (8'($urandom) & 8'hE0)) : 8'($urandom);
      cyc(($urandom % 4) != 0, d, 2'($urandom), ($urandom % 4) != 0, sc,
          ($urandom % 8) == 0, ($urandom % 6) == 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule